// File: doc/BRIEF.md
# Prescaled Free-Running Timer

This block is a 16-bit up-counter that runs continuously from the peripheral clock through a selectable power-of-two prescaler. Software controls it through one 8-bit control/status register on a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data. A second address returns the live count. The control register can restart the count from zero, freeze it, choose the division ratio, and arm an overflow interrupt.

A mode bit links the counter to an external compare unit. When the mode bit is set, a compare-match input that coincides with a count tick returns the counter to zero instead of letting it advance. The timer then repeats with a programmable period. The overflow flag is sticky. Software clears it by writing 0, and writing 1 to it leaves it unchanged. The interrupt output is the flag gated by its enable bit.

Top module: `tmr_freerun`

## Requirements
- R1: After reset the control register reads 0x00, the count reads 0x0000 and `irq` is low.
- R2: With stop clear and clock-select value k (bits 2:0 of the control register), the count advances by one every 2^k clock cycles. The prescaler phase restarts at every counter clear, so the first advance comes 2^k edges after the clearing write.
- R3: A control write with bit 3 set makes the count read 0x0000 after that edge. A write with bit 3 clear does not touch the count. Bit 3 always reads 0.
- R4: While the stop bit (bit 5) is 1, the count and the prescaler phase hold their values.
- R5: With the mode bit (bit 4) at 1, a tick that coincides with a high `cmp_match` loads 0x0000 and does not set the flag. With the mode bit at 0, `cmp_match` has no effect.
- R6: A tick taken while the count is 0xFFFF wraps the count to 0x0000 and sets the flag (bit 7).
- R7: A control write with bit 7 at 0 clears the flag. A write with bit 7 at 1 leaves the flag unchanged. When a wrap and a clearing write fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when both the flag and the enable bit (bit 6) are 1.
- R9: Address 0 reads {flag, enable, stop, mode, 0, select[2:0]} in bits 7:0, with the upper bits 0. Address 1 reads the 16-bit count. Other addresses read 0 and ignore writes.
- R10: Between edges without a clear, the count either holds, advances by exactly one, or goes to zero. A new select value takes effect from the current prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data for the control register |
| bus_rdata | output | 16 | Read data for the addressed register |
| cmp_match | input | 1 | Compare-match event from the external compare unit |
| irq | output | 1 | Overflow interrupt request |

## Verification
A wrong prescaler phase shows up as a count that drifts by one tick relative to the clearing write. It is visible at address 1 within 2^k cycles at the current select value. A corrupted flag or enable shows at `irq` and at bit 7 or 6 of address 0 on the cycle after the bad edge. A compare-match that is wrongly honoured or ignored shows as a count that differs from the model on the next tick. A wrong wrap condition is exposed by the full 65536-tick run, in which the flag must rise on exactly one edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CTRL_W   = 8;
   localparam int BIT_FLAG = 7;
   localparam int BIT_EN   = 6;
   localparam int BIT_STOP = 5;
   localparam int BIT_MODE = 4;
   localparam int BIT_CLR  = 3;

   typedef struct packed {
      logic       flag;
      logic       en;
      logic       stop;
      logic       mode;
      logic [2:0] sel;
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PRE_W = (1 << SEL_W) - 1;

   initial begin
      if (SEL_W < 1 || SEL_W > 4) $error("tmr_prescale: SEL_W out of range");
   end

   logic [PRE_W-1:0] phase;
   logic [PRE_W:0]   onehot;
   logic [PRE_W-1:0] mask;

   always_comb begin
      onehot = {{PRE_W{1'b0}}, 1'b1} << sel;
      mask   = onehot[PRE_W-1:0] - {{(PRE_W-1){1'b0}}, 1'b1};
      tick   = run && ((phase & mask) == mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase <= '0;
      else if (restart) phase <= '0;
      else if (run)     phase <= phase + 1'b1;
   end

   // R4: a stopped prescaler never issues a tick and keeps its phase
   a_r4_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(phase));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W     = 16,
   parameter bit CMP_CLEAR = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             tick,
   input  logic             mode,
   input  logic             match,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   initial begin
      if (CNT_W < 8 || CNT_W > 32) $error("tmr_count: CNT_W out of range");
   end

   logic reload;

   generate
      if (CMP_CLEAR) begin : g_cmp
         assign reload = tick && mode && match;
      end else begin : g_nocmp
         assign reload = 1'b0;
      end
   endgenerate

   assign wrap = tick && !clear && !reload && (count == {CNT_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (clear)  count <= '0;
      else if (reload) count <= '0;
      else if (tick)   count <= count + 1'b1;
   end

   // R3: a clear request zeroes the count on the next edge
   a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (count == '0));

   // R10: no jump larger than one step, apart from returning to zero
   a_r10_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

   // R5: a honoured match returns the count to zero and is not a wrap
   a_r5_match_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (CMP_CLEAR && tick && mode && match) |=> (count == '0));

   // R4: no tick means the count holds unless cleared
   a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !clear) |=> $stable(count));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
   import tmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              set_flag,
   output tmr_ctrl_t         ctrl,
   output logic              clr_req
);
   assign clr_req = wr && wdata[BIT_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else begin
         if (wr) begin
            ctrl.en   <= wdata[BIT_EN];
            ctrl.stop <= wdata[BIT_STOP];
            ctrl.mode <= wdata[BIT_MODE];
            ctrl.sel  <= wdata[2:0];
         end
         if (set_flag)                    ctrl.flag <= 1'b1;
         else if (wr && !wdata[BIT_FLAG]) ctrl.flag <= 1'b0;
      end
   end

   // R7: the set event wins over a clearing write
   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_flag |=> ctrl.flag);

   // R7: writing 0 clears the flag when nothing sets it
   a_r7_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wdata[BIT_FLAG] && !set_flag) |=> !ctrl.flag);

   // R7: writing 1 leaves the flag as it was
   a_r7_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wdata[BIT_FLAG] && !set_flag) |=> (ctrl.flag == $past(ctrl.flag)));
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun
   import tmr_pkg::*;
#(
   parameter int          ADDR_W    = 2,
   parameter int          CNT_W     = 16,
   parameter int          SEL_W     = 3,
   parameter logic [1:0]  CTRL_ADDR = 2'd0,
   parameter logic [1:0]  CNT_ADDR  = 2'd1,
   parameter bit          CMP_CLEAR = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [CTRL_W-1:0] bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              cmp_match,
   output logic              irq
);
   initial begin
      if (SEL_W != 3)            $error("tmr_freerun: control layout needs SEL_W == 3");
      if (CNT_W < CTRL_W)        $error("tmr_freerun: CNT_W narrower than control word");
      if (CTRL_ADDR == CNT_ADDR) $error("tmr_freerun: address clash");
   end

   tmr_ctrl_t        ctrl;
   logic             ctrl_wr;
   logic             clr_req;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] count;

   assign ctrl_wr = bus_we && (bus_addr == ADDR_W'(CTRL_ADDR));

   tmr_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ctrl_wr),
      .wdata    (bus_wdata),
      .set_flag (wrap),
      .ctrl     (ctrl),
      .clr_req  (clr_req)
   );

   tmr_prescale #(.SEL_W(SEL_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (!ctrl.stop),
      .restart (clr_req),
      .sel     (ctrl.sel),
      .tick    (tick)
   );

   tmr_count #(.CNT_W(CNT_W), .CMP_CLEAR(CMP_CLEAR)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (clr_req),
      .tick  (tick),
      .mode  (ctrl.mode),
      .match (cmp_match),
      .count (count),
      .wrap  (wrap)
   );

   logic [CTRL_W-1:0] ctrl_view;
   assign ctrl_view = {ctrl.flag, ctrl.en, ctrl.stop, ctrl.mode, 1'b0, ctrl.sel};

   always_comb begin
      if (bus_addr == ADDR_W'(CTRL_ADDR))     bus_rdata = CNT_W'(ctrl_view);
      else if (bus_addr == ADDR_W'(CNT_ADDR)) bus_rdata = count;
      else                                    bus_rdata = '0;
   end

   assign irq = ctrl.flag && ctrl.en;

   // R6: a wrap raises the flag on the following edge
   a_r6_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ctrl.flag);

   // R4: while stopped and not cleared the count holds
   a_r4_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.stop && !clr_req) |=> $stable(count));

   // R9: the clear bit reads back as 0
   a_r9_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(CTRL_ADDR)) |-> (bus_rdata[BIT_CLR] == 1'b0));

   // R8: the interrupt follows the flag only while enabled
   a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (ctrl.en && (ctrl.flag || $past(wrap))));
endmodule

// File: tb/sim_tmr_freerun.sv
module sim_tmr_freerun;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = 8'd0;
   logic [15:0] bus_rdata;
   logic        cmp_match = 1'b0;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   logic [6:0]  m_pre = '0;
   logic [15:0] m_cnt = '0;
   logic        m_flag = 0, m_en = 0, m_stop = 0, m_mode = 0;
   logic [2:0]  m_sel = '0;
   int          wraps = 0;

   tmr_freerun u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_match(cmp_match), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [15:0] expect_read(input logic [1:0] a);
      if (a == 2'd0) return {8'h00, m_flag, m_en, m_stop, m_mode, 1'b0, m_sel};
      if (a == 2'd1) return m_cnt;
      return 16'h0000;
   endfunction

   function automatic logic ticks_now();
      logic [6:0] mask;
      mask = 7'((8'd1 << m_sel) - 8'd1);
      return !m_stop && ((m_pre & mask) == mask);
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input string tag, input logic we, input logic [1:0] a,
                       input logic [7:0] wd, input logic match);
      logic clr, tk, rl, wr_ctrl, wrp;
      bus_we = we; bus_addr = a; bus_wdata = wd; cmp_match = match;
      @(posedge clk);
      wr_ctrl = we && (a == 2'd0);
      clr = wr_ctrl && wd[3];
      tk  = ticks_now();
      rl  = tk && m_mode && match;
      wrp = tk && !clr && !rl && (m_cnt == 16'hFFFF);
      if (clr)       m_cnt = '0;
      else if (rl)   m_cnt = '0;
      else if (tk)   m_cnt = m_cnt + 1'b1;
      if (clr)          m_pre = '0;
      else if (!m_stop) m_pre = m_pre + 1'b1;
      if (wrp) begin m_flag = 1'b1; wraps++; end
      else if (wr_ctrl && !wd[7]) m_flag = 1'b0;
      if (wr_ctrl) begin
         m_en = wd[6]; m_stop = wd[5]; m_mode = wd[4]; m_sel = wd[2:0];
      end
      @(negedge clk);
      check(tag, bus_rdata, expect_read(a));
      check("R8", {15'd0, irq}, {15'd0, m_flag && m_en});
   endtask

   task automatic idle(input string tag, input int n, input logic [1:0] a);
      for (int i = 0; i < n; i++) step(tag, 1'b0, a, 8'h00, 1'b0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      summary();
   end

   initial begin
      int seed;
      seed = $urandom(20240611);
      @(negedge clk);
      // R1: reset state
      check("R1", bus_rdata, 16'h0000);
      bus_addr = 2'd1; #1;
      check("R1", bus_rdata, 16'h0000);
      check("R1", {15'd0, irq}, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: divide by 1 and by 8, phase restarts on clear
      step("R3", 1'b1, 2'd0, 8'h08, 1'b0);
      idle("R2", 20, 2'd1);
      check("R2", bus_rdata, 16'd20);
      step("R3", 1'b1, 2'd0, 8'h0B, 1'b0);
      idle("R2", 24, 2'd1);
      check("R2", bus_rdata, 16'd3);
      // R3: writing 0 to clear bit keeps the count, bit reads 0
      step("R3", 1'b1, 2'd0, 8'h83, 1'b0);
      idle("R3", 1, 2'd0);
      // R10: select change mid-run
      step("R10", 1'b1, 2'd0, 8'h81, 1'b0);
      idle("R10", 13, 2'd1);
      // R4: stop holds
      step("R4", 1'b1, 2'd0, 8'hA0, 1'b0);
      idle("R4", 10, 2'd1);
      step("R4", 1'b1, 2'd0, 8'h80, 1'b0);
      idle("R4", 5, 2'd1);
      // R5: mode 0 ignores match, mode 1 honours it
      for (int i = 0; i < 6; i++) step("R5", 1'b0, 2'd1, 8'h00, 1'b1);
      step("R5", 1'b1, 2'd0, 8'h90, 1'b0);
      idle("R5", 4, 2'd1);
      step("R5", 1'b0, 2'd1, 8'h00, 1'b1);
      check("R5", bus_rdata, 16'h0000);
      idle("R5", 3, 2'd1);
      // R9: unused address
      step("R9", 1'b1, 2'd2, 8'hFF, 1'b0);
      step("R9", 1'b0, 2'd3, 8'h00, 1'b0);
      // R6: full wrap at divide by 1, enabled interrupt
      step("R3", 1'b1, 2'd0, 8'hC8, 1'b0);
      idle("R6", 65535, 2'd1);
      check("R6", bus_rdata, 16'hFFFF);
      wraps = 0;
      step("R6", 1'b0, 2'd0, 8'h00, 1'b0);
      check("R6", {15'd0, irq}, 16'd1);
      check("R6", 16'(wraps), 16'd1);
      // R7: writing 1 keeps, writing 0 clears
      step("R7", 1'b1, 2'd0, 8'hC0, 1'b0);
      check("R7", {15'd0, bus_rdata[7]}, 16'd1);
      step("R7", 1'b1, 2'd0, 8'h40, 1'b0);
      check("R7", {15'd0, bus_rdata[7]}, 16'd0);
      // R7: set wins over clearing write in the same cycle
      step("R3", 1'b1, 2'd0, 8'hC8, 1'b0);
      idle("R7", 65535, 2'd1);
      step("R7", 1'b1, 2'd0, 8'h40, 1'b0);
      check("R7", {15'd0, bus_rdata[7]}, 16'd1);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int r;
         logic [7:0] wd;
         r = $urandom_range(0, 99);
         wd = 8'($urandom());
         if ($urandom_range(0, 9) != 0) wd[3] = 1'b0;
         if ($urandom_range(0, 3) != 0) wd[5] = 1'b0;
         if ($urandom_range(0, 3) != 0) wd[7] = 1'b1;
         if (r < 12)
            step("R10", 1'b1, 2'd0, wd, $urandom_range(0, 4) == 0);
         else
            step("R2", 1'b0, 2'($urandom_range(0, 3)), 8'h00, $urandom_range(0, 4) == 0);
      end
      summary();
   end
endmodule